// File: doc/BRIEF.md
# NOR Flash Command Sequencer

This block decodes the bus writes of a parallel NOR flash that uses an unlock-sequence command set. Every command must be preceded by a two-write unlock handshake. The block holds the word array itself. It performs bit-clearing program writes and whole-sector or whole-chip erases. It reports which view the read path should present: array data, identification, query table, program pending or erase in progress.

An erase fills its region with all ones, walking the array one word per clock. A busy timer runs for at least as long as that walk. A bypass mode lets a host issue many commands without repeating the unlock pair. All address comparisons use the word offset: the byte address shifted right by 1 for 16-bit devices and by 2 for 32-bit devices.

Top module: `nor_cmd_seq`

## Requirements
- R1: After reset, `mode_o` is 0 (read), `busy_o` and `bypass_o` are 0, and every array word reads all ones.
- R2: From read mode, a command needs data 0xAA at word offset UNLOCK0 (default 0x555) and then 0x55 at UNLOCK1 (default 0x2AA). A mismatch on either write returns the block to read mode.
- R3: The third write selects the command and must go to UNLOCK0 unless bypass is active. 0x80 selects erase setup, 0x90 selects autoselect (`mode_o`=1), 0xA0 selects program (`mode_o`=3) and 0x20 enters bypass. Any other value, or a wrong address, returns to read mode.
- R4: In program mode, the next write ANDs its data into the addressed word, so bits only go from 1 to 0. The block then returns to read mode (`mode_o`=0), or to command select when bypass is active.
- R5: A write of 0xF0 returns the block to read mode and clears bypass in every state except two: while a program awaits its data write, and while an erase is busy.
- R6: A write of 0x98 at word offset 0x55 enters query mode (`mode_o`=2) from read mode or from autoselect. Any write while in query mode returns the block to read mode.
- R7: Sector erase is 0x80, then 0xAA/0x55 at the unlock offsets, then 0x30 at any address. It sets to all ones every word of the sector that holds the addressed word, and leaves the other sectors untouched.
- R8: Chip erase is the same sequence ending in 0x10 at UNLOCK0. It sets every array word to all ones. If 0x10 goes to any other address, the block returns to read mode without erasing.
- R9: During an erase, `mode_o`=4 and `busy_o`=1 for max(SECTOR_BUSY, SECTOR_WORDS) cycles (sector) or max(CHIP_BUSY, array words) cycles (chip), counted from the clock that accepts the final command write. Every write in that window, 0xF0 included, is ignored.
- R10: 0x20 at command select sets `bypass_o`. Command writes then need no unlock pair and no fixed address. In bypass with autoselect active, data 0x00 clears bypass and returns to read mode.
- R11: The word offset is the byte address shifted right by log2 of the device width in bytes. For a 16-bit device, byte address 0x554 is word 0x2AA, not UNLOCK0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write strobe, one write per cycle it is high |
| wr_addr | input | CMD_BITS+log2(DEV_BYTES) | Byte address of the write |
| wr_data | input | 8*DEV_BYTES | Write data; bits 7:0 carry the command code |
| rd_index | input | log2(array words) | Word index for the array read port |
| rd_data | output | 8*DEV_BYTES | Array word at `rd_index`, registered one cycle |
| mode_o | output | 3 | 0 read, 1 autoselect, 2 query, 3 program pending, 4 erase busy |
| busy_o | output | 1 | Erase in progress |
| bypass_o | output | 1 | Unlock bypass active |

## Verification
The assertions assume that every write is aligned to the device width, so the byte-lane bits of `wr_addr` are zero. One assertion checks this input condition directly. They also assume that the chip-erase busy setting is at least the sector one, so that the timer width covers both. The bench meets the first assumption by building every write address from a word offset shifted left, and it keeps the default timings. It reads the array only through `rd_index`, and only after an erase has finished, so it never catches a walk half done.

// File: rtl/nfcs_pkg.sv
package nfcs_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_UNL1, ST_CMD, ST_PROG, ST_ASEL,
    ST_EUNL0, ST_EUNL1, ST_ECMD, ST_BUSY, ST_CFI
  } seq_state_t;

  localparam logic [2:0] MODE_READ = 3'd0;
  localparam logic [2:0] MODE_ASEL = 3'd1;
  localparam logic [2:0] MODE_QRY  = 3'd2;
  localparam logic [2:0] MODE_PROG = 3'd3;
  localparam logic [2:0] MODE_BUSY = 3'd4;

  // byte-lane shift for a device width in bytes
  function automatic int lane_shift(input int bytes);
    return (bytes >= 4) ? 2 : (bytes == 2) ? 1 : 0;
  endfunction

  // busy window never shorter than the erase walk
  function automatic int busy_cycles(input int setting, input int walk);
    return (setting > walk) ? setting : walk;
  endfunction

endpackage

// File: rtl/nor_busy_timer.sv
module nor_busy_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          busy,
  output logic          done
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
  assign done = (cnt == CW'(1)) && !load;

  AST_DONE_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy); // R9

endmodule

// File: rtl/nor_word_array.sv
module nor_word_array #(
  parameter int DW    = 16,
  parameter int WORDS = 64,
  localparam int IW   = $clog2(WORDS),
  localparam int LW   = $clog2(WORDS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prog_en,
  input  logic [IW-1:0] prog_idx,
  input  logic [DW-1:0] prog_data,
  input  logic          wipe_start,
  input  logic [IW-1:0] wipe_base,
  input  logic [LW-1:0] wipe_len,
  input  logic [IW-1:0] rd_idx,
  output logic [DW-1:0] rd_data,
  output logic          wipe_active
);
  logic [DW-1:0] mem [WORDS];
  logic [IW-1:0] ptr;
  logic [LW-1:0] left;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '1;
      ptr     <= '0;
      left    <= '0;
      rd_data <= '1;
    end else begin
      if (wipe_start) begin
        ptr  <= wipe_base;
        left <= wipe_len;
      end else if (left != '0) begin
        mem[ptr] <= '1;
        ptr      <= ptr + 1'b1;
        left     <= left - 1'b1;
      end
      if (prog_en) mem[prog_idx] <= mem[prog_idx] & prog_data;
      rd_data <= mem[rd_idx];
    end
  end

  assign wipe_active = (left != '0);

  AST_WIPE_NO_PROG: assert property (@(posedge clk) disable iff (!rst_n)
    wipe_active |-> !prog_en); // R9

endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
  import nfcs_pkg::*;
#(
  parameter int          DEV_BYTES    = 2,
  parameter int          CMD_BITS     = 11,
  parameter int          SECTOR_WORDS = 16,
  parameter int          NUM_SECTORS  = 4,
  parameter logic [10:0] UNLOCK0      = 11'h555,
  parameter logic [10:0] UNLOCK1      = 11'h2AA,
  parameter int          CHIP_BUSY    = 200,
  parameter int          SECTOR_BUSY  = 40,
  localparam int BSH   = lane_shift(DEV_BYTES),
  localparam int DW    = 8 * DEV_BYTES,
  localparam int AW    = CMD_BITS + BSH,
  localparam int WORDS = SECTOR_WORDS * NUM_SECTORS,
  localparam int IW    = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [IW-1:0] rd_index,
  output logic [DW-1:0] rd_data,
  output logic [2:0]    mode_o,
  output logic          busy_o,
  output logic          bypass_o
);
  localparam int CHIP_CYC = busy_cycles(CHIP_BUSY, WORDS);
  localparam int SECT_CYC = busy_cycles(SECTOR_BUSY, SECTOR_WORDS);
  localparam int TW       = $clog2(CHIP_CYC + 1);
  localparam int LW       = $clog2(WORDS + 1);
  localparam logic [CMD_BITS-1:0] QRY_OFS = CMD_BITS'(8'h55);

  seq_state_t state, nxt_state;
  logic       bypass_q, nxt_bypass;

  // decoded write fields
  logic [CMD_BITS-1:0] wr_word;
  logic [7:0]          cmd_byte;
  logic [IW-1:0]       wr_idx;
  logic                at_u0, at_u1, at_qry;

  assign wr_word  = wr_addr[AW-1:BSH];
  assign cmd_byte = wr_data[7:0];
  assign wr_idx   = wr_word[IW-1:0];
  assign at_u0    = (wr_word == UNLOCK0[CMD_BITS-1:0]);
  assign at_u1    = (wr_word == UNLOCK1[CMD_BITS-1:0]);
  assign at_qry   = (wr_word == QRY_OFS);

  // internal events
  logic          prog_en, wipe_start, wipe_active;
  logic [IW-1:0] wipe_base;
  logic [LW-1:0] wipe_len;
  logic          tmr_load, tmr_busy, tmr_done;
  logic [TW-1:0] tmr_val;

  always_comb begin
    nxt_state  = state;
    nxt_bypass = bypass_q;
    prog_en    = 1'b0;
    wipe_start = 1'b0;
    wipe_base  = '0;
    wipe_len   = '0;
    tmr_load   = 1'b0;
    tmr_val    = '0;
    if (state == ST_BUSY) begin
      if (tmr_done) nxt_state = bypass_q ? ST_CMD : ST_IDLE;
    end else if (wr_en) begin
      if (state != ST_PROG && cmd_byte == 8'hF0) begin
        nxt_state  = ST_IDLE;
        nxt_bypass = 1'b0;
      end else begin
        nxt_state  = ST_IDLE;          // default for any mismatch
        nxt_bypass = 1'b0;
        unique case (state)
          ST_IDLE: begin
            if (at_qry && cmd_byte == 8'h98)      nxt_state = ST_CFI;
            else if (at_u0 && cmd_byte == 8'hAA)  nxt_state = ST_UNL1;
          end
          ST_UNL1:  if (at_u1 && cmd_byte == 8'h55) nxt_state = ST_CMD;
          ST_CMD: begin
            if (bypass_q || at_u0) begin
              nxt_bypass = bypass_q;
              case (cmd_byte)
                8'h20: begin nxt_state = ST_CMD;   nxt_bypass = 1'b1; end
                8'h80:       nxt_state = ST_EUNL0;
                8'h90:       nxt_state = ST_ASEL;
                8'hA0:       nxt_state = ST_PROG;
                default: begin nxt_state = ST_IDLE; nxt_bypass = 1'b0; end
              endcase
            end
          end
          ST_PROG: begin
            prog_en    = 1'b1;
            nxt_bypass = bypass_q;
            nxt_state  = bypass_q ? ST_CMD : ST_IDLE;
          end
          ST_ASEL: begin
            if (!(bypass_q && cmd_byte == 8'h00) && at_qry && cmd_byte == 8'h98) begin
              nxt_state  = ST_CFI;
              nxt_bypass = bypass_q;
            end
          end
          ST_EUNL0: if (at_u0 && cmd_byte == 8'hAA) begin
            nxt_state = ST_EUNL1; nxt_bypass = bypass_q;
          end
          ST_EUNL1: if (at_u1 && cmd_byte == 8'h55) begin
            nxt_state = ST_ECMD; nxt_bypass = bypass_q;
          end
          ST_ECMD: begin
            if (cmd_byte == 8'h10 && at_u0) begin
              nxt_state  = ST_BUSY;
              nxt_bypass = bypass_q;
              wipe_start = 1'b1;
              wipe_len   = LW'(WORDS);
              tmr_load   = 1'b1;
              tmr_val    = TW'(CHIP_CYC);
            end else if (cmd_byte == 8'h30) begin
              nxt_state  = ST_BUSY;
              nxt_bypass = bypass_q;
              wipe_start = 1'b1;
              wipe_base  = wr_idx & ~IW'(SECTOR_WORDS - 1);
              wipe_len   = LW'(SECTOR_WORDS);
              tmr_load   = 1'b1;
              tmr_val    = TW'(SECT_CYC);
            end
          end
          default: ;                      // ST_CFI: any write leaves
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      bypass_q <= 1'b0;
    end else begin
      state    <= nxt_state;
      bypass_q <= nxt_bypass;
    end
  end

  always_comb begin
    case (state)
      ST_ASEL: mode_o = MODE_ASEL;
      ST_CFI:  mode_o = MODE_QRY;
      ST_PROG: mode_o = MODE_PROG;
      ST_BUSY: mode_o = MODE_BUSY;
      default: mode_o = MODE_READ;
    endcase
  end
  assign busy_o   = (state == ST_BUSY);
  assign bypass_o = bypass_q;

  nor_word_array #(.DW(DW), .WORDS(WORDS)) u_array (
    .clk(clk), .rst_n(rst_n),
    .prog_en(prog_en), .prog_idx(wr_idx), .prog_data(wr_data),
    .wipe_start(wipe_start), .wipe_base(wipe_base), .wipe_len(wipe_len),
    .rd_idx(rd_index), .rd_data(rd_data), .wipe_active(wipe_active)
  );

  nor_busy_timer #(.CW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
    .busy(tmr_busy), .done(tmr_done)
  );

  // byte-lane bits exist only for wide devices
  generate
    if (BSH > 0) begin : g_lane
      logic [BSH-1:0] lane;
      assign lane = wr_addr[BSH-1:0];
      AST_ALIGNED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (lane == '0)); // R11
    end
  endgenerate

  AST_F0_TO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && cmd_byte == 8'hF0 && state != ST_PROG && state != ST_BUSY)
      |=> (mode_o == MODE_READ && !bypass_o)); // R5
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_BUSY && !tmr_done) |=> (state == ST_BUSY)); // R9
  AST_BUSY_MATCHES_TIMER: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_BUSY) |-> tmr_busy); // R9
  AST_WIPE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    wipe_active |-> (state == ST_BUSY)); // R7
  AST_PROG_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
    prog_en |=> (state == ST_IDLE || state == ST_CMD)); // R4
  AST_BYPASS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bypass_q) |-> ($past(state) == ST_CMD && $past(cmd_byte) == 8'h20)); // R10

endmodule

// File: tb/tb_nor_cmd_seq.sv
module tb_nor_cmd_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [11:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [5:0]  rd_index = '0;
  logic [15:0] rd_data;
  logic [2:0]  mode_o;
  logic        busy_o, bypass_o;

  int vectors = 0;
  int fails   = 0;

  always #4 clk = ~clk;

  nor_cmd_seq dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_index(rd_index), .rd_data(rd_data),
    .mode_o(mode_o), .busy_o(busy_o), .bypass_o(bypass_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_b(input logic [11:0] ba, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = ba; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr(input logic [10:0] w, input logic [15:0] d);
    wr_b({w, 1'b0}, d);
  endtask

  task automatic rd(input logic [5:0] idx, output logic [15:0] v);
    @(negedge clk); rd_index = idx;
    @(negedge clk); v = rd_data;
  endtask

  task automatic unlock();
    wr(11'h555, 16'h00AA); wr(11'h2AA, 16'h0055);
  endtask

  task automatic program_word(input logic [5:0] idx, input logic [15:0] d);
    unlock(); wr(11'h555, 16'h00A0); wr({5'd0, idx}, d);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    chk("R1 mode", mode_o, 0); chk("R1 busy", busy_o, 0); chk("R1 bypass", bypass_o, 0);
    rd(6'd5, v);  chk("R1 word5", v, 16'hFFFF);
    rd(6'd63, v); chk("R1 word63", v, 16'hFFFF);
  endtask

  task automatic t_program();
    logic [15:0] v;
    unlock(); wr(11'h555, 16'h00A0);
    chk("R3 program mode", mode_o, 3);
    wr(11'd3, 16'h1234);
    chk("R4 back to read", mode_o, 0);
    rd(6'd3, v); chk("R4 programmed", v, 16'h1234);
    program_word(6'd3, 16'hFF0F);
    rd(6'd3, v); chk("R4 and-merge", v, 16'h1204);
  endtask

  task automatic t_bad_unlock();
    logic [15:0] v;
    wr(11'h555, 16'h00AA); wr(11'h2AB, 16'h0055);
    chk("R2 mismatch read", mode_o, 0);
    wr(11'h555, 16'h00A0); wr(11'd4, 16'h0000);
    rd(6'd4, v); chk("R2 no program", v, 16'hFFFF);
    wr(11'h555, 16'h00AB); wr(11'h2AA, 16'h0055); wr(11'h555, 16'h00A0);
    chk("R2 bad first data", mode_o, 0);
  endtask

  task automatic t_bad_cmd();
    logic [15:0] v;
    unlock(); wr(11'h100, 16'h00A0);
    chk("R3 wrong cmd addr", mode_o, 0);
    wr(11'd6, 16'h0000);
    rd(6'd6, v); chk("R3 no program", v, 16'hFFFF);
    unlock(); wr(11'h555, 16'h0077);
    chk("R3 unknown cmd", mode_o, 0);
    unlock(); wr(11'h555, 16'h0090);
    chk("R3 autoselect", mode_o, 1);
    wr(11'h000, 16'h00F0);
    chk("R5 F0 from autoselect", mode_o, 0);
    unlock(); wr(11'h555, 16'h0080); wr(11'h123, 16'h00F0);
    chk("R5 F0 in erase setup", mode_o, 0);
  endtask

  task automatic t_f0_program();
    logic [15:0] v;
    unlock(); wr(11'h555, 16'h00A0); wr(11'd7, 16'h00F0);
    chk("R5 F0 as data mode", mode_o, 0);
    rd(6'd7, v); chk("R5 F0 programmed", v, 16'h00F0);
  endtask

  task automatic t_cfi();
    wr(11'h055, 16'h0098); chk("R6 query from read", mode_o, 2);
    wr(11'h000, 16'h0000); chk("R6 write leaves query", mode_o, 0);
    wr(11'h056, 16'h0098); chk("R6 wrong offset", mode_o, 0);
    unlock(); wr(11'h555, 16'h0090); wr(11'h055, 16'h0098);
    chk("R6 query from autoselect", mode_o, 2);
    wr(11'h123, 16'h00FF); chk("R6 leave again", mode_o, 0);
  endtask

  task automatic t_sector();
    logic [15:0] v;
    int cnt;
    program_word(6'd20, 16'h0000);
    program_word(6'd16, 16'h5555);
    unlock(); wr(11'h555, 16'h0080); unlock(); wr(11'h013, 16'h0030);
    chk("R9 sector busy mode", mode_o, 4);
    cnt = 0;
    while (busy_o && cnt < 1000) begin cnt++; @(negedge clk); end
    chk("R9 sector duration", cnt, 40);
    chk("R7 back to read", mode_o, 0);
    rd(6'd20, v); chk("R7 word20 erased", v, 16'hFFFF);
    rd(6'd16, v); chk("R7 sector base erased", v, 16'hFFFF);
    rd(6'd3, v);  chk("R7 other sector kept", v, 16'h1204);
    rd(6'd7, v);  chk("R7 other sector kept 7", v, 16'h00F0);
  endtask

  task automatic t_chip();
    logic [15:0] v;
    int cnt;
    unlock(); wr(11'h555, 16'h0080); unlock(); wr(11'h100, 16'h0010);
    chk("R8 bad addr mode", mode_o, 0); chk("R8 bad addr busy", busy_o, 0);
    rd(6'd3, v); chk("R8 no erase", v, 16'h1204);
    unlock(); wr(11'h555, 16'h0080); unlock(); wr(11'h555, 16'h0010);
    chk("R9 chip busy mode", mode_o, 4);
    cnt = 4;
    wr(11'h555, 16'h00F0); wr(11'h555, 16'h00AA);
    chk("R9 F0 ignored", mode_o, 4); chk("R9 still busy", busy_o, 1);
    while (busy_o && cnt < 1000) begin cnt++; @(negedge clk); end
    chk("R9 chip duration", cnt, 200);
    rd(6'd3, v);  chk("R8 word3 erased", v, 16'hFFFF);
    rd(6'd7, v);  chk("R8 word7 erased", v, 16'hFFFF);
    rd(6'd63, v); chk("R8 word63 erased", v, 16'hFFFF);
  endtask

  task automatic t_bypass();
    logic [15:0] v;
    unlock(); wr(11'h555, 16'h0020);
    chk("R10 bypass set", bypass_o, 1); chk("R10 mode read", mode_o, 0);
    wr(11'h077, 16'h00A0); chk("R10 program no unlock", mode_o, 3);
    wr(11'd9, 16'h0F0F);
    chk("R4 bypass kept", bypass_o, 1);
    rd(6'd9, v); chk("R10 word9", v, 16'h0F0F);
    wr(11'h300, 16'h00A0); wr(11'd10, 16'h3C3C);
    rd(6'd10, v); chk("R10 word10", v, 16'h3C3C);
    wr(11'h000, 16'h0090); chk("R10 autoselect", mode_o, 1);
    wr(11'h000, 16'h0000);
    chk("R10 bypass cleared", bypass_o, 0); chk("R10 read mode", mode_o, 0);
    wr(11'h077, 16'h00A0); wr(11'd11, 16'h0000);
    rd(6'd11, v); chk("R10 unlock needed again", v, 16'hFFFF);
    unlock(); wr(11'h555, 16'h0020); wr(11'h000, 16'h00F0);
    chk("R5 F0 clears bypass", bypass_o, 0);
  endtask

  task automatic t_width();
    logic [15:0] v;
    wr_b(12'h554, 16'h00AA); wr_b(12'h554, 16'h0055);
    wr_b(12'hAAA, 16'h00A0); wr_b(12'h02A, 16'h0000);
    rd(6'd21, v); chk("R11 byte 0x554 not unlock", v, 16'hFFFF);
    wr_b(12'hAAA, 16'h00AA); wr_b(12'h554, 16'h0055);
    wr_b(12'hAAA, 16'h00A0); wr_b(12'h02C, 16'h00FF);
    rd(6'd22, v); chk("R11 shifted program", v, 16'h00FF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_program();
    t_bad_unlock();
    t_bad_cmd();
    t_f0_program();
    t_cfi();
    t_sector();
    t_chip();
    t_bypass();
    t_width();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule